// File: doc/BRIEF.md
# Wavefront Memory Address Coalescer

This block sits between the lanes of one wavefront memory instruction and the cache. It takes one address per lane and a mask of active lanes. It merges all active lanes that fall in the same cache block into a single block request. Each distinct block goes out once on a valid/ready request port, together with a lane mask naming the lanes it serves. In the common case every lane touches one block, and a whole wavefront costs a single cache access.

The block holds the wavefront as one unit. A new wavefront is refused until every block request issued for the current one has been answered on the response input. A one-cycle done pulse then releases the wavefront. The scan over the lanes is sequential: it finds at most one new block per cycle, starting each time from the lowest-numbered lane that still waits.

Top module: `wf_coalescer`

## Requirements
- R1: The block address of a lane is its address shifted right by log2(BLOCK_BYTES). BLOCK_BYTES is a power of two and defaults to 64. `req_block` is ADDR_W - log2(BLOCK_BYTES) bits wide.
- R2: Each distinct block among the active lanes is requested exactly once. Bit i of `req_lanes` is 1 exactly when lane i is active and lies in that block.
- R3: When all active lanes share one block, exactly one request is issued, and its lane mask equals the active mask.
- R4: Requests leave in ascending order of the lowest-numbered lane that references each block.
- R5: The address of an inactive lane (mask bit 0) has no effect on any request.
- R6: A wavefront accepted with an all-zero mask issues no request and raises `wf_done` in the cycle after acceptance.
- R7: Each `rsp_valid` cycle returns one issued request. `wf_done` is a one-cycle pulse. It rises two cycles after the `rsp_valid` cycle that returns the last outstanding request, and never while a request is unanswered.
- R8: `wf_ready` drops in the cycle after acceptance and stays low until the cycle in which `wf_done` is high. While it is low, `wf_valid`, `wf_addr` and `wf_mask` are ignored.
- R9: While `req_valid` is high and `req_ready` is low, `req_valid`, `req_block` and `req_lanes` hold steady.
- R10: After reset, `wf_ready` is 1 and both `req_valid` and `wf_done` are 0.
- R11: With `req_ready` held high, the k-th request (counting from 0) is presented k cycles after the cycle that follows acceptance, one per cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| wf_valid | input | 1 | Wavefront presented |
| wf_ready | output | 1 | Idle, wavefront can be taken |
| wf_addr | input | LANES*ADDR_W | Lane addresses, lane i at bits [i*ADDR_W +: ADDR_W] |
| wf_mask | input | LANES | Active lanes |
| req_valid | output | 1 | Block request valid |
| req_ready | input | 1 | Downstream takes request |
| req_block | output | ADDR_W-log2(BLOCK_BYTES) | Block address |
| req_lanes | output | LANES | Lanes served by the request |
| rsp_valid | input | 1 | One block response returned |
| wf_done | output | 1 | Wavefront complete pulse |

## Verification
The assertions check on every cycle that a request under back-pressure holds steady, that no request appears while idle, and that no request names a lane outside the accepted mask or names no lane at all. They also check that done never fires with responses owed and lasts one cycle. Only the bench scenarios can show which blocks are produced, their order, how lanes merge, the cost of one request when all lanes share a block, the exact done latency and the request rate. The bench sweeps every mask of an eight-lane configuration over address sets with heavy block collisions. It also varies back-pressure and response delay.

// File: rtl/coal_pkg.sv
package coal_pkg;
    typedef enum logic {
        CS_IDLE = 1'b0,
        CS_BUSY = 1'b1
    } coal_state_e;
endpackage

// File: rtl/coal_first.sv
// Lowest set bit finder: returns the index of the lowest pending lane.
module coal_first #(
    parameter int N     = 64,
    parameter int IDX_W = 6
) (
    input  logic [N-1:0]     vec,
    output logic             found,
    output logic [IDX_W-1:0] idx
);
    always_comb begin
        found = 1'b0;
        idx   = '0;
        for (int i = N - 1; i >= 0; i--) begin
            if (vec[i]) begin
                found = 1'b1;
                idx   = IDX_W'(i);
            end
        end
    end
endmodule

// File: rtl/coal_match.sv
// Comparator array: flags every pending lane whose block equals the key.
module coal_match #(
    parameter int N = 64,
    parameter int W = 26
) (
    input  logic [N-1:0][W-1:0] blocks,
    input  logic [W-1:0]        key,
    input  logic [N-1:0]        pending,
    output logic [N-1:0]        hit
);
    for (genvar g = 0; g < N; g++) begin : g_cmp
        assign hit[g] = pending[g] && (blocks[g] == key);
    end
endmodule

// File: rtl/wf_coalescer.sv
module wf_coalescer #(
    parameter int LANES       = 64,
    parameter int ADDR_W      = 32,
    parameter int BLOCK_BYTES = 64
) (
    input  logic                              clk,
    input  logic                              rst_n,
    input  logic                              wf_valid,
    output logic                              wf_ready,
    input  logic [LANES*ADDR_W-1:0]           wf_addr,
    input  logic [LANES-1:0]                  wf_mask,
    output logic                              req_valid,
    input  logic                              req_ready,
    output logic [ADDR_W-$clog2(BLOCK_BYTES)-1:0] req_block,
    output logic [LANES-1:0]                  req_lanes,
    input  logic                              rsp_valid,
    output logic                              wf_done
);
    import coal_pkg::*;

    localparam int OFF_W = $clog2(BLOCK_BYTES);
    localparam int BLK_W = ADDR_W - OFF_W;
    localparam int IDX_W = (LANES > 1) ? $clog2(LANES) : 1;
    localparam int CNT_W = $clog2(LANES + 1);

    typedef struct packed {
        coal_state_e                   state;
        logic [LANES-1:0]              pend;
        logic [LANES-1:0][BLK_W-1:0]   blk;
        logic [CNT_W-1:0]              owed;
        logic                          done;
    } coal_regs_t;

    coal_regs_t r_q, r_d;

    // Block tags of the incoming wavefront (offset bits dropped).
    logic [LANES-1:0][BLK_W-1:0] in_blk;
    for (genvar g = 0; g < LANES; g++) begin : g_tag
        assign in_blk[g] = wf_addr[g*ADDR_W+OFF_W +: BLK_W];
    end

    logic             first_found;
    logic [IDX_W-1:0] first_idx;
    logic [LANES-1:0] hit;
    logic [BLK_W-1:0] key;

    coal_first #(.N(LANES), .IDX_W(IDX_W)) u_first (
        .vec   (r_q.pend),
        .found (first_found),
        .idx   (first_idx)
    );

    assign key = r_q.blk[first_idx];

    coal_match #(.N(LANES), .W(BLK_W)) u_match (
        .blocks  (r_q.blk),
        .key     (key),
        .pending (r_q.pend),
        .hit     (hit)
    );

    logic fire_w;
    logic ret_w;

    always_comb begin
        r_d      = r_q;
        r_d.done = 1'b0;
        fire_w   = (r_q.state == CS_BUSY) && first_found && req_ready;
        ret_w    = rsp_valid && (r_q.owed != '0);
        r_d.owed = r_q.owed + CNT_W'(fire_w) - CNT_W'(ret_w);
        case (r_q.state)
            CS_IDLE: begin
                if (wf_valid) begin
                    if (wf_mask == '0) begin
                        r_d.done = 1'b1;
                    end else begin
                        r_d.state = CS_BUSY;
                        r_d.pend  = wf_mask;
                        r_d.blk   = in_blk;
                    end
                end
            end
            CS_BUSY: begin
                if (fire_w) begin
                    r_d.pend = r_q.pend & ~hit;
                end
                if (r_q.pend == '0 && r_q.owed == '0) begin
                    r_d.state = CS_IDLE;
                    r_d.done  = 1'b1;
                end
            end
            default: r_d.state = CS_IDLE;
        endcase
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            r_q.state <= CS_IDLE;
            r_q.pend  <= '0;
            r_q.blk   <= '0;
            r_q.owed  <= '0;
            r_q.done  <= 1'b0;
        end else begin
            r_q <= r_d;
        end
    end

    assign wf_ready  = (r_q.state == CS_IDLE);
    assign req_valid = (r_q.state == CS_BUSY) && first_found;
    assign req_block = key;
    assign req_lanes = hit;
    assign wf_done   = r_q.done;
endmodule

// File: rtl/coal_checker.sv
module coal_checker #(
    parameter int LANES       = 64,
    parameter int ADDR_W      = 32,
    parameter int BLOCK_BYTES = 64
) (
    input logic                                  clk,
    input logic                                  rst_n,
    input logic                                  wf_valid,
    input logic                                  wf_ready,
    input logic [LANES-1:0]                      wf_mask,
    input logic                                  req_valid,
    input logic                                  req_ready,
    input logic [ADDR_W-$clog2(BLOCK_BYTES)-1:0] req_block,
    input logic [LANES-1:0]                      req_lanes,
    input logic                                  rsp_valid,
    input logic                                  wf_done
);
    localparam int CNT_W = $clog2(LANES + 1);

    logic [LANES-1:0] mask_seen;
    logic [CNT_W-1:0] unanswered;

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            mask_seen  <= '0;
            unanswered <= '0;
        end else begin
            if (wf_valid && wf_ready) mask_seen <= wf_mask;
            unanswered <= unanswered
                        + CNT_W'(req_valid && req_ready)
                        - CNT_W'(rsp_valid && unanswered != '0);
        end
    end

    p_hold_r9: assert property (@(posedge clk) disable iff (!rst_n)
        req_valid && !req_ready |=> req_valid && $stable(req_block) && $stable(req_lanes));

    p_idle_quiet_r8: assert property (@(posedge clk) disable iff (!rst_n)
        wf_ready |-> !req_valid);

    p_lanes_in_mask_r5: assert property (@(posedge clk) disable iff (!rst_n)
        req_valid |-> (req_lanes & ~mask_seen) == '0);

    p_lanes_nonempty_r2: assert property (@(posedge clk) disable iff (!rst_n)
        req_valid |-> req_lanes != '0);

    p_done_settled_r7: assert property (@(posedge clk) disable iff (!rst_n)
        wf_done |-> unanswered == '0);

    p_done_pulse_r7: assert property (@(posedge clk) disable iff (!rst_n)
        wf_done |=> !wf_done);
endmodule

bind wf_coalescer coal_checker #(
    .LANES(LANES), .ADDR_W(ADDR_W), .BLOCK_BYTES(BLOCK_BYTES)
) u_chk (
    .clk(clk), .rst_n(rst_n), .wf_valid(wf_valid), .wf_ready(wf_ready),
    .wf_mask(wf_mask), .req_valid(req_valid), .req_ready(req_ready),
    .req_block(req_block), .req_lanes(req_lanes), .rsp_valid(rsp_valid),
    .wf_done(wf_done)
);

// File: tb/wf_coalescer_test.sv
`timescale 1ns/1ps
module wf_coalescer_test;
    localparam int L  = 8;
    localparam int AW = 10;
    localparam int BB = 16;
    localparam int OW = 4;
    localparam int BW = AW - OW;

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic wf_valid = 1'b0;
    logic wf_ready;
    logic [L*AW-1:0] wf_addr = '0;
    logic [L-1:0] wf_mask = '0;
    logic req_valid;
    logic req_ready = 1'b0;
    logic [BW-1:0] req_block;
    logic [L-1:0] req_lanes;
    logic rsp_valid = 1'b0;
    logic wf_done;

    int total = 0;
    int bad = 0;
    int cycles = 0;

    always #2.5 clk = ~clk;

    wf_coalescer #(.LANES(L), .ADDR_W(AW), .BLOCK_BYTES(BB)) uut (
        .clk(clk), .rst_n(rst_n), .wf_valid(wf_valid), .wf_ready(wf_ready),
        .wf_addr(wf_addr), .wf_mask(wf_mask), .req_valid(req_valid),
        .req_ready(req_ready), .req_block(req_block), .req_lanes(req_lanes),
        .rsp_valid(rsp_valid), .wf_done(wf_done)
    );

    task automatic chk(input bit ok, input string rq, input string what,
                       input longint act, input longint exp);
        total++;
        if (!ok) begin
            bad++;
            $display("FAIL %s %s: actual=%0h expected=%0h", rq, what, act, exp);
        end
    endtask

    always @(posedge clk) begin
        cycles++;
        if (cycles > 150000) begin
            bad++;
            total++;
            $display("FAIL watchdog: actual=%0d expected=%0d", cycles, 150000);
            $display("test done: total=%0d bad=%0d", total, bad);
            $finish;
        end
    end

    function automatic bit rdy_pat(input int mode, input int c);
        case (mode)
            0: return 1'b1;
            1: return (c % 2) == 1;
            default: return (c % 3) == 2;
        endcase
    endfunction

    task automatic run_wave(input logic [L-1:0][AW-1:0] a, input logic [L-1:0] m,
                            input int rmode, input int dly, input bit junk);
        logic [BW-1:0] eb [L];
        logic [L-1:0]  em [L];
        logic [L-1:0]  seen;
        int ne, k, rh, cyc, last_rsp;
        int due [L];
        bit fin;
        ne = 0;
        seen = '0;
        // Expected requests: first-appearance order over active lanes.
        for (int i = 0; i < L; i++) begin
            if (m[i] && !seen[i]) begin
                eb[ne] = a[i][AW-1:OW];
                em[ne] = '0;
                for (int j = 0; j < L; j++) begin
                    if (m[j] && a[j][AW-1:OW] == a[i][AW-1:OW]) begin
                        em[ne][j] = 1'b1;
                        seen[j] = 1'b1;
                    end
                end
                ne++;
            end
        end
        @(negedge clk);
        chk(wf_ready == 1'b1, "R8", "ready before wave", longint'(wf_ready), 1);
        wf_addr = a;
        wf_mask = m;
        wf_valid = 1'b1;
        @(negedge clk);
        if (junk) begin
            wf_addr = ~a;
            wf_mask = ~m;
        end else begin
            wf_valid = 1'b0;
        end
        k = 0; rh = 0; cyc = 0; last_rsp = -10; fin = 1'b0;
        while (!fin && cyc < 3000) begin
            if (wf_done) begin
                chk(k == ne, "R2", "request count", longint'(k), longint'(ne));
                chk(rh == ne, "R7", "responses before done", longint'(rh), longint'(ne));
                if (ne == 0)
                    chk(cyc == 0, "R6", "empty wave done cycle", longint'(cyc), 0);
                else
                    chk(cyc == last_rsp + 2, "R7", "done latency",
                        longint'(cyc), longint'(last_rsp + 2));
                chk(wf_ready == 1'b1, "R8", "ready with done", longint'(wf_ready), 1);
                fin = 1'b1;
            end else begin
                if (ne > 0)
                    chk(wf_ready == 1'b0, "R8", "ready while busy", longint'(wf_ready), 0);
                rsp_valid = 1'b0;
                if (rh < k && due[rh] <= cyc) begin
                    rsp_valid = 1'b1;
                    rh++;
                    last_rsp = cyc;
                end
                req_ready = rdy_pat(rmode, cyc);
                if (req_valid && req_ready) begin
                    if (k < ne) begin
                        chk(req_block == eb[k], "R1 R4 R5", "block",
                            longint'(req_block), longint'(eb[k]));
                        chk(req_lanes == em[k], "R2 R5", "lane mask",
                            longint'(req_lanes), longint'(em[k]));
                        if (rmode == 0)
                            chk(cyc == k, "R11", "request cycle", longint'(cyc), longint'(k));
                        due[k] = cyc + dly;
                    end else begin
                        chk(1'b0, "R2", "extra request", longint'(k), longint'(ne));
                    end
                    k++;
                end
                @(negedge clk);
                cyc++;
            end
        end
        if (!fin) chk(1'b0, "R7", "wave never done", longint'(cyc), 0);
        wf_valid = 1'b0;
        rsp_valid = 1'b0;
        req_ready = 1'b0;
        @(negedge clk);
        chk(wf_done == 1'b0, "R7", "done one cycle", longint'(wf_done), 0);
    endtask

    initial begin
        logic [L-1:0][AW-1:0] a;
        logic [31:0] h;
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        chk(wf_ready == 1'b1, "R10", "reset ready", longint'(wf_ready), 1);
        chk(req_valid == 1'b0, "R10", "reset req_valid", longint'(req_valid), 0);
        chk(wf_done == 1'b0, "R10", "reset done", longint'(wf_done), 0);

        // R3 R1: one block, offsets differ
        for (int i = 0; i < L; i++) a[i] = AW'(10'h150 + i);
        run_wave(a, 8'hFF, 0, 1, 1'b0);
        run_wave(a, 8'h5A, 1, 4, 1'b0);
        // R4: distinct blocks, descending addresses
        for (int i = 0; i < L; i++) a[i] = AW'((L - 1 - i) << OW);
        run_wave(a, 8'hFF, 0, 2, 1'b0);
        // R6: empty mask
        run_wave(a, 8'h00, 0, 1, 1'b0);
        // R8: new wavefront held on the input while busy is ignored
        run_wave(a, 8'hC3, 2, 3, 1'b1);
        // Near-exhaustive sweep over all masks with colliding blocks
        h = 32'h1234_5678;
        for (int mm = 0; mm < 256; mm++) begin
            for (int i = 0; i < L; i++) begin
                h = h ^ (h << 13); h = h ^ (h >> 17); h = h ^ (h << 5);
                a[i] = AW'((((h % 3) + (mm % 4)) << OW) | (h[11:8] & 4'hF));
            end
            run_wave(a, 8'(mm), mm % 3, 1 + (mm % 5), 1'b0);
        end
        // Wider block spread
        for (int w = 0; w < 120; w++) begin
            for (int i = 0; i < L; i++) begin
                h = h ^ (h << 13); h = h ^ (h >> 17); h = h ^ (h << 5);
                a[i] = AW'(h[AW-1:0]);
                if (h[31:30] == 2'b00 && i > 0) a[i] = a[i-1] ^ AW'(h[3:0]);
            end
            h = h ^ (h << 13); h = h ^ (h >> 17); h = h ^ (h << 5);
            run_wave(a, h[L-1:0], w % 3, 1 + (w % 7), w % 4 == 1);
        end
        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    end
endmodule